// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the eight status flags of an asynchronous serial port and produces its interrupt request. Separate transmit and receive engines report what happens on the line as single-cycle pulses: a word moved from the transmit holding register into the shifter, a transmitted frame ended, a received word is ready (with noise, framing and parity qualifiers), and an idle line was seen. The block turns these pulses into sticky flags and exposes them as one 8-bit status word.

Software clears the flags with a two-step handshake. It first reads the status word, then touches the data register. A data write clears the transmit-side flags. A data read clears the receive-side flags. The parity flag is cleared by either kind of access. Only flags that were already set when the status was read are cleared, so events that arrive in between are not lost.

The block also tells the transmit engine when it may load a new word. It gates the update of the receive holding register when a new word would overrun an unread one. It folds the enabled sources into a registered interrupt request.

Top module: `uart_flag_ctrl`

## Requirements
- R1: The status word has tx_empty at bit 7, tx_done at bit 6, rx_full at bit 5, line_idle at bit 4, overrun at bit 3, noise at bit 2, frame_err at bit 1 and parity_err at bit 0. After reset it reads 0xC0.
- R2: tx_load_ok is high exactly while status bit 7 is 0. A load pulse accepted while bit 7 is 0 sets bit 7 on the next clock edge.
- R3: A frame-end pulse sets bit 6 only when tx_frame_special is low. A preamble or break frame (tx_frame_special high) leaves bit 6 unchanged.
- R4: A ready pulse while bit 5 is 0 asserts rx_hold_upd in the same cycle and sets bit 5 at the next edge. Its noise, framing and parity qualifiers set bits 2, 1 and 0 at that same edge.
- R5: A ready pulse while bit 5 is 1 sets bit 3 and does not assert rx_hold_upd. Bits 2, 1 and 0 are not changed by that word, so a framing error that comes with an overrun leaves bit 1 clear.
- R6: An idle pulse sets bit 4. After bit 4 has been set once, further idle pulses are ignored until bit 5 has been set by an accepted word.
- R7: A status read arms the clear. The next data write clears bits 7, 6 and 0, and the next data read clears bits 5 to 0, in each case only the bits that were 1 at the status read. Any data access ends the sequence. A data access with no sequence armed clears nothing.
- R8: A flag that becomes set after the status read survives the data access that completes the sequence.
- R9: When a set event and a clear for the same flag fall in the same cycle, the flag stays 1.
- R10: irq_en bit 0 enables tx_empty, bit 1 enables tx_done, bit 2 enables rx_full or overrun, bit 3 enables line_idle and bit 4 enables parity_err. Noise and frame_err never raise an interrupt. irq is a registered OR of the enabled sources and follows the flags one cycle later.
- R11: A status read in the same cycle as a data access applies the previously armed snapshot to that access. It then arms a new snapshot for the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_load | input | 1 | Transmit engine moved the holding word into the shifter |
| ev_tx_frame_end | input | 1 | Transmit engine finished a frame |
| tx_frame_special | input | 1 | Qualifies frame end: the frame was a preamble or break |
| ev_rx_ready | input | 1 | Receive engine has a complete word |
| rx_noise | input | 1 | Qualifier of ev_rx_ready: noise seen |
| rx_frame_err | input | 1 | Qualifier of ev_rx_ready: framing error or break |
| rx_parity_err | input | 1 | Qualifier of ev_rx_ready: parity mismatch |
| ev_rx_idle | input | 1 | Receive engine detected an idle line |
| stat_rd | input | 1 | Register bus read of the status word |
| data_rd | input | 1 | Register bus read of the data register |
| data_wr | input | 1 | Register bus write of the data register |
| irq_en | input | 5 | Interrupt enables, mapping in R10 |
| status | output | 8 | Status word, layout in R1 |
| tx_load_ok | output | 1 | Transmit engine may load the shifter |
| rx_hold_upd | output | 1 | Strobe to copy the received word into the holding register |
| irq | output | 1 | Interrupt request |

## Verification
Flag results are due one clock edge after the pulse or access that causes them. The bench drives every stimulus for one cycle from a falling edge and reads status at the next falling edge. rx_hold_upd is combinational, so it is sampled shortly after the inputs are driven, in the same cycle. irq is one register later than the flags, so each interrupt check waits one extra falling edge after the enables or flags change. The drop after a clear is checked on both sides of that extra cycle. The enable sweep covers all 32 enable patterns against several flag states, and the expected request is computed arithmetically from the R10 mapping.

// File: rtl/uart_flag_pkg.sv
// Shared constants for the UART status flag controller: status word
// layout, reset value, clear masks and interrupt enable positions.
package uart_flag_pkg;
    localparam int STAT_W = 8;
    localparam int IRQ_W  = 5;

    // Status bit positions (software decodes these)
    localparam int B_TXE = 7;
    localparam int B_TXD = 6;
    localparam int B_RXF = 5;
    localparam int B_IDL = 4;
    localparam int B_OVR = 3;
    localparam int B_NSE = 2;
    localparam int B_FRM = 1;
    localparam int B_PAR = 0;

    localparam logic [STAT_W-1:0] STAT_RST = (STAT_W'(1) << B_TXE) | (STAT_W'(1) << B_TXD);
    // Flags cleared by a data write / by a data read after a status read
    localparam logic [STAT_W-1:0] WR_CLR_MASK = STAT_RST | (STAT_W'(1) << B_PAR);
    localparam logic [STAT_W-1:0] RD_CLR_MASK = ~STAT_RST;

    // Interrupt enable positions
    localparam int IE_TXE = 0;
    localparam int IE_TXD = 1;
    localparam int IE_RX  = 2;
    localparam int IE_IDL = 3;
    localparam int IE_PAR = 4;
endpackage

// File: rtl/uart_flag_cell.sv
// One sticky status flag. Assumes set and clr are single-cycle requests;
// a set request takes priority over a clear in the same cycle.
module uart_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register: reset value, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/uart_clear_seq.sv
// Two-step clear sequencer. A status read captures the current flags as
// the armed snapshot. The next data access clears the armed flags its
// mask allows and ends the sequence. Assumes bus strobes are one cycle wide.
module uart_clear_seq
    import uart_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] clr_vec
);
    logic [STAT_W-1:0] arm_q;
    logic [STAT_W-1:0] acc_mask;

    // Snapshot register: a status read re-arms, a data access disarms
    always_ff @(posedge clk) begin
        if (!rst_n)                 arm_q <= '0;
        else if (stat_rd)           arm_q <= status;
        else if (data_rd | data_wr) arm_q <= '0;
    end

    // Mask of the flags the current data access is allowed to clear
    always_comb begin
        acc_mask = '0;
        if (data_wr) acc_mask = acc_mask | WR_CLR_MASK;
        if (data_rd) acc_mask = acc_mask | RD_CLR_MASK;
    end

    // Clear requests: armed flags within the access mask
    always_comb clr_vec = arm_q & acc_mask;

    // R7
    disarm_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_rd || data_wr) && !stat_rd) |=> (arm_q == '0));
endmodule

// File: rtl/uart_event_decode.sv
// Turns engine pulses into per-flag set requests. Applies the overrun
// rule, the special-frame exclusion and the idle re-arm rule. Assumes the
// receive qualifiers are only meaningful in the cycle of ev_rx_ready.
module uart_event_decode
    import uart_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_load,
    input  logic              ev_tx_frame_end,
    input  logic              tx_frame_special,
    input  logic              ev_rx_ready,
    input  logic              rx_noise,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              ev_rx_idle,
    input  logic              cur_txe,
    input  logic              cur_rxf,
    input  logic              cur_idl,
    output logic [STAT_W-1:0] set_vec,
    output logic              rx_accept
);
    logic idle_arm_q;
    logic rx_overrun;

    // Word acceptance versus overrun, decided by the current rx_full flag
    always_comb begin
        rx_accept  = ev_rx_ready & ~cur_rxf;
        rx_overrun = ev_rx_ready &  cur_rxf;
    end

    // Per-flag set requests
    always_comb begin
        set_vec        = '0;
        set_vec[B_TXE] = ev_tx_load & ~cur_txe;
        set_vec[B_TXD] = ev_tx_frame_end & ~tx_frame_special;
        set_vec[B_RXF] = rx_accept;
        set_vec[B_IDL] = ev_rx_idle & idle_arm_q;
        set_vec[B_OVR] = rx_overrun;
        set_vec[B_NSE] = rx_accept & rx_noise;
        set_vec[B_FRM] = rx_accept & rx_frame_err;
        set_vec[B_PAR] = rx_accept & rx_parity_err;
    end

    // Idle re-arm: consumed by an idle set, restored by an accepted word
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_arm_q <= 1'b1;
        else if (rx_accept)         idle_arm_q <= 1'b1;
        else if (set_vec[B_IDL])    idle_arm_q <= 1'b0;
    end

    // R6
    idle_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_idle && !idle_arm_q && !cur_idl) |=> !cur_idl);

    // R6
    idle_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_idle && idle_arm_q) |=> cur_idl);
endmodule

// File: rtl/uart_irq_gen.sv
// Registered interrupt request: OR of the enabled sources. Assumes the
// source vector comes straight from flag registers.
module uart_irq_gen
    import uart_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] src,
    input  logic [IRQ_W-1:0] irq_en,
    output logic             irq
);
    // Request register
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(src & irq_en);
    end

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src & irq_en)) |=> irq);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(src & irq_en)) |=> !irq);
endmodule

// File: rtl/uart_flag_ctrl.sv
// UART status flag controller top. Holds the status flags in one cell per
// bit, clears them through the status-read/data-access handshake and
// drives the interrupt request. Assumes all inputs are synchronous to clk.
module uart_flag_ctrl
    import uart_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_load,
    input  logic              ev_tx_frame_end,
    input  logic              tx_frame_special,
    input  logic              ev_rx_ready,
    input  logic              rx_noise,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              ev_rx_idle,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [IRQ_W-1:0]  irq_en,
    output logic [STAT_W-1:0] status,
    output logic              tx_load_ok,
    output logic              rx_hold_upd,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [IRQ_W-1:0]  irq_src;
    logic              rx_accept;

    uart_event_decode u_dec (
        .clk              (clk),
        .rst_n            (rst_n),
        .ev_tx_load       (ev_tx_load),
        .ev_tx_frame_end  (ev_tx_frame_end),
        .tx_frame_special (tx_frame_special),
        .ev_rx_ready      (ev_rx_ready),
        .rx_noise         (rx_noise),
        .rx_frame_err     (rx_frame_err),
        .rx_parity_err    (rx_parity_err),
        .ev_rx_idle       (ev_rx_idle),
        .cur_txe          (status[B_TXE]),
        .cur_rxf          (status[B_RXF]),
        .cur_idl          (status[B_IDL]),
        .set_vec          (set_vec),
        .rx_accept        (rx_accept)
    );

    uart_clear_seq u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .status  (status),
        .clr_vec (clr_vec)
    );

    // One flag cell per status bit, reset value taken from the package
    for (genvar g = 0; g < STAT_W; g++) begin : g_flag
        uart_flag_cell #(.RST_VAL(STAT_RST[g])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[g]),
            .clr   (clr_vec[g]),
            .q     (status[g])
        );
    end

    // Interrupt sources in enable order
    always_comb begin
        irq_src         = '0;
        irq_src[IE_TXE] = status[B_TXE];
        irq_src[IE_TXD] = status[B_TXD];
        irq_src[IE_RX]  = status[B_RXF] | status[B_OVR];
        irq_src[IE_IDL] = status[B_IDL];
        irq_src[IE_PAR] = status[B_PAR];
    end

    uart_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (irq_src),
        .irq_en (irq_en),
        .irq    (irq)
    );

    // Engine-side outputs
    always_comb begin
        tx_load_ok  = ~status[B_TXE];
        rx_hold_upd = rx_accept;
    end

    // R4
    rx_strobe_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hold_upd |=> status[B_RXF]);

    // R5
    overrun_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ready && status[B_RXF]) |-> !rx_hold_upd);

    // R5
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ready && status[B_RXF]) |=> status[B_OVR]);

    // R7
    fall_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(data_rd || data_wr));

    // R3
    special_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_frame_end && tx_frame_special && !status[B_TXD]) |=> !status[B_TXD]);
endmodule

// File: tb/sim_uart_flag_ctrl.sv
// Self-checking bench for uart_flag_ctrl: directed flag scenarios plus a
// full sweep of interrupt enables against several flag states.
module sim_uart_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tx_load = 0, ev_tx_frame_end = 0, tx_frame_special = 0;
    logic       ev_rx_ready = 0, rx_noise = 0, rx_frame_err = 0, rx_parity_err = 0;
    logic       ev_rx_idle = 0, stat_rd = 0, data_rd = 0, data_wr = 0;
    logic [4:0] irq_en = '0;
    logic [7:0] status;
    logic       tx_load_ok, rx_hold_upd, irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    logic last_upd;

    // Stimulus code bits
    localparam logic [10:0] SR  = 11'h400, DR  = 11'h200, DW  = 11'h100;
    localparam logic [10:0] TXL = 11'h080, TXE = 11'h040, TXS = 11'h020;
    localparam logic [10:0] RXR = 11'h010, RXI = 11'h008, NZ  = 11'h004;
    localparam logic [10:0] FE  = 11'h002, PE  = 11'h001;

    always #10 clk = ~clk;

    uart_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_load(ev_tx_load), .ev_tx_frame_end(ev_tx_frame_end),
        .tx_frame_special(tx_frame_special), .ev_rx_ready(ev_rx_ready),
        .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .ev_rx_idle(ev_rx_idle),
        .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .irq_en(irq_en), .status(status), .tx_load_ok(tx_load_ok),
        .rx_hold_upd(rx_hold_upd), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a falling edge; status valid at the next
    task automatic op(input logic [10:0] v);
        @(negedge clk);
        {stat_rd, data_rd, data_wr, ev_tx_load, ev_tx_frame_end, tx_frame_special,
         ev_rx_ready, ev_rx_idle, rx_noise, rx_frame_err, rx_parity_err} = v;
        #1 last_upd = rx_hold_upd;
        @(negedge clk);
        {stat_rd, data_rd, data_wr, ev_tx_load, ev_tx_frame_end, tx_frame_special,
         ev_rx_ready, ev_rx_idle, rx_noise, rx_frame_err, rx_parity_err} = '0;
    endtask

    function automatic logic exp_irq(input logic [7:0] s, input logic [4:0] en);
        return (en[0] & s[7]) | (en[1] & s[6]) | (en[2] & (s[5] | s[3]))
             | (en[3] & s[4]) | (en[4] & s[0]);
    endfunction

    // R10: every enable pattern against one flag state, irq one cycle later
    task automatic sweep(input logic [7:0] s);
        for (int e = 0; e < 32; e++) begin
            @(negedge clk);
            irq_en = 5'(e);
            @(negedge clk);
            chk("R10 irq sweep", {7'd0, irq}, {7'd0, exp_irq(s, 5'(e))});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset value", status, 8'hC0);
        chk("R2 no load permit after reset", {7'd0, tx_load_ok}, 8'h00);
        chk("R10 irq low after reset", {7'd0, irq}, 8'h00);

        op(SR); op(DW);
        chk("R7 write clears tx flags", status, 8'h00);
        chk("R2 load permit with tx_empty clear", {7'd0, tx_load_ok}, 8'h01);
        op(TXL);
        chk("R2 load sets tx_empty", status, 8'h80);
        chk("R2 permit withdrawn", {7'd0, tx_load_ok}, 8'h00);
        op(TXE | TXS);
        chk("R3 special frame leaves tx_done", status, 8'h80);
        op(TXE);
        chk("R3 data frame sets tx_done", status, 8'hC0);
        op(DW);
        chk("R7 unarmed write clears nothing", status, 8'hC0);
        op(SR); op(DW);
        chk("R7 armed write clears", status, 8'h00);

        op(RXR | NZ | PE);
        chk("R4 strobe on accepted word", {7'd0, last_upd}, 8'h01);
        chk("R4 flags of accepted word", status, 8'h25);
        op(RXR | FE);
        chk("R5 no strobe on overrun", {7'd0, last_upd}, 8'h00);
        chk("R5 overrun set, frame_err clear", status, 8'h2D);
        op(SR); op(DW);
        chk("R7 write spares rx flags, clears parity", status, 8'h2C);
        op(SR); op(DR);
        chk("R7 read clears rx flags", status, 8'h00);

        op(RXI);
        chk("R6 idle sets", status, 8'h10);
        op(SR); op(DR);
        chk("R7 read clears idle", status, 8'h00);
        op(RXI);
        chk("R6 idle blocked until rx_full", status, 8'h00);
        op(RXR);
        chk("R4 rx_full set", status, 8'h20);
        op(RXI);
        chk("R6 idle re-armed", status, 8'h30);
        op(SR); op(DR);
        chk("R7 read clears both", status, 8'h00);

        op(SR); op(RXR); op(DR);
        chk("R8 late flag survives", status, 8'h20);
        op(SR); op(DR);
        chk("R8 later sequence clears", status, 8'h00);

        op(TXL); op(TXE);
        chk("R3 tx flags set", status, 8'hC0);
        op(SR); op(DW | TXE);
        chk("R9 set beats clear", status, 8'h40);
        op(SR); op(DW);
        chk("R9 cleared afterwards", status, 8'h00);

        op(TXL);
        op(SR | DW);
        chk("R11 same-cycle access uses old snapshot", status, 8'h80);
        op(DW);
        chk("R11 new snapshot armed", status, 8'h00);

        op(TXL); op(TXE); op(RXR | NZ | FE | PE); op(RXI); op(RXR);
        chk("R1 all flags set", status, 8'hFF);
        sweep(8'hFF);
        op(SR); op(DW);
        chk("R7 write clears 7,6,0", status, 8'h3E);
        sweep(8'h3E);
        op(SR); op(DR);
        chk("R7 read clears rest", status, 8'h00);
        sweep(8'h00);
        op(RXR | NZ | FE);
        chk("R4 noise and frame_err set", status, 8'h26);
        sweep(8'h26);

        @(negedge clk);
        irq_en = 5'b00100;
        @(negedge clk);
        chk("R10 rx enable raises irq", {7'd0, irq}, 8'h01);
        op(SR); op(DR);
        chk("R10 irq held one cycle after clear", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R10 irq drops next cycle", {7'd0, irq}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule